// File: doc/BRIEF.md
# Hardware Cursor and Crosshair Overlay

This block sits in a video output path and produces, for every pixel the display scans, one overlay bit. The bit says whether a 64x64 one-bit cursor image covers that pixel, or whether a crosshair does. The crosshair is a horizontal and a vertical line of selectable thickness, clipped to a rectangular window. A command register enables each of the two shapes and chooses whether their results merge by OR or by XOR. It also picks the pixel multiplex ratio. In a multiplexed mode the block emits four or five neighbouring pixels on every clock.

The block follows the raster on its own, using the horizontal and vertical sync inputs. A fixed, mode-dependent pipeline offset is subtracted from the programmed horizontal position. Software therefore programs a horizontal coordinate that already contains that offset. Configuration arrives through a byte-wide register write port and a byte-wide cursor image write port.

Top module: `cursor_overlay`

## Requirements
- R1: While reset is low, and after it is released with no configuration written, the output `ovl` is all zeros.
- R2: When command bit 6 (cursor enable) and bit 5 (crosshair enable) are both clear, every bit of `ovl` is zero, whatever the position, window and image.
- R3: The cursor image is written as byte `map_addr`, holding row `map_addr[8:3]` and columns `8*map_addr[2:0]+j` for bit `j`. A lane pixel at raster column `x` and line `v` is covered when `dx = x + P - xpos` and `dy = v - ypos` both lie in 0..63 and image bit (dy, dx) is 1. P is 37 in 1:1 mode, 52 in 4:1 mode and 57 in 5:1 mode.
- R4: The crosshair covers a pixel when crosshair enable is set, the pixel lies inside the window (`wx <= x < wx+ww` and `wy <= v < wy+wh`), and `|dx| <= r` or `|dy| <= r`. The value r is command bits 1:0, which gives a line thickness of 2r+1. A window of zero width or height shows no crosshair.
- R5: Command bit 4 set merges cursor and crosshair by OR. Clear merges them by XOR.
- R6: Command bits 3:2 select the ratio: 00 is 1:1, 01 is 4:1, 10 is 5:1, and 11 acts as 1:1. In an N:1 mode, `ovl[k]` is pixel `x+k` for k < N, the unused lanes are zero, and the column counter advances by N per clock.
- R7: On the clock that samples a falling `hsync`, the column counter becomes 0. `ovl` after a clock edge reflects the counter value held just before that edge.
- R8: The first `hsync` fall after a `vsync` fall sets the line counter to 0. Each later `hsync` fall adds one to it.
- R9: Register writes map as follows. Address 0 is the command. Addresses 2 and 3 are xpos low and high. Addresses 4 and 5 are ypos low and high; each position is 12 bits wide, and the high byte keeps only its bits 3:0. Addresses 8 and 9 are wx, 10 and 11 are wy, 12 and 13 are ww, and 14 and 15 are wh, each as a low and high byte pair. Writes to addresses 1, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write byte |
| map_we | input | 1 | Cursor image write strobe |
| map_addr | input | 9 | Cursor image byte address |
| map_wdata | input | 8 | Cursor image byte |
| hsync | input | 1 | Horizontal sync, active low |
| vsync | input | 1 | Vertical sync, active low |
| ovl | output | 5 | Overlay bits, lane k is pixel x+k |

## Verification
The hardest case to reach is a shape edge that falls inside a multiplexed pixel group. Here some lanes of one clock are inside the cursor square or crosshair window and others are outside, and they must line up with the mode's pipeline offset. The stimulus reaches this case by sweeping whole frames in every mode, with positions and windows chosen so that the edges land at odd lane positions. Every output bit of every line is compared with an arithmetic model of the coordinates. Frames start with a vsync pulse followed by hsync pulses, so the line numbering is checked from the first line of each frame.

// File: rtl/cxo_pkg.sv
// Shared constants and types for the cursor/crosshair overlay.
// Assumes byte-wide configuration writes and at most five lanes per clock.
package cxo_pkg;
    localparam int POS_W  = 12;   // cursor position width
    localparam int WIN_W  = 16;   // crosshair window field width
    localparam int LANES  = 5;    // widest multiplex ratio
    localparam int STEP_W = 3;    // holds a lane count

    typedef enum logic [1:0] {
        MUX_1   = 2'b00,
        MUX_4   = 2'b01,
        MUX_5   = 2'b10,
        MUX_RSV = 2'b11
    } mux_e;

    typedef struct packed {
        logic [7:0]       cmd;
        logic [POS_W-1:0] xpos;
        logic [POS_W-1:0] ypos;
        logic [WIN_W-1:0] wx;
        logic [WIN_W-1:0] wy;
        logic [WIN_W-1:0] ww;
        logic [WIN_W-1:0] wh;
    } cfg_t;

    localparam logic [3:0] A_CMD = 4'd0;
    localparam logic [3:0] A_XLO = 4'd2;
    localparam logic [3:0] A_XHI = 4'd3;
    localparam logic [3:0] A_YLO = 4'd4;
    localparam logic [3:0] A_YHI = 4'd5;
    localparam logic [3:0] A_WXL = 4'd8;
    localparam logic [3:0] A_WXH = 4'd9;
    localparam logic [3:0] A_WYL = 4'd10;
    localparam logic [3:0] A_WYH = 4'd11;
    localparam logic [3:0] A_WWL = 4'd12;
    localparam logic [3:0] A_WWH = 4'd13;
    localparam logic [3:0] A_WHL = 4'd14;
    localparam logic [3:0] A_WHH = 4'd15;

    // Number of pixels emitted per clock for a multiplex code.
    function automatic logic [STEP_W-1:0] lanes_of(mux_e m);
        case (m)
            MUX_4:   return STEP_W'(4);
            MUX_5:   return STEP_W'(5);
            default: return STEP_W'(1);
        endcase
    endfunction
endpackage

// File: rtl/cxo_regs.sv
// Configuration register file.
// Holds command, cursor position and crosshair window; assumes one byte per write.
module cxo_regs
    import cxo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [3:0] addr,
    input  logic [7:0] wdata,
    output cfg_t       cfg
);
    // Byte-lane update of the addressed field; unmapped addresses are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                A_CMD: cfg.cmd            <= wdata;
                A_XLO: cfg.xpos[7:0]      <= wdata;
                A_XHI: cfg.xpos[POS_W-1:8] <= wdata[POS_W-9:0];
                A_YLO: cfg.ypos[7:0]      <= wdata;
                A_YHI: cfg.ypos[POS_W-1:8] <= wdata[POS_W-9:0];
                A_WXL: cfg.wx[7:0]        <= wdata;
                A_WXH: cfg.wx[15:8]       <= wdata;
                A_WYL: cfg.wy[7:0]        <= wdata;
                A_WYH: cfg.wy[15:8]       <= wdata;
                A_WWL: cfg.ww[7:0]        <= wdata;
                A_WWH: cfg.ww[15:8]       <= wdata;
                A_WHL: cfg.wh[7:0]        <= wdata;
                A_WHH: cfg.wh[15:8]       <= wdata;
                default: ;
            endcase
        end
    end

    // R9: a command write lands on the next edge
    a_r9_cmd_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == A_CMD) |=> (cfg.cmd == $past(wdata)));
endmodule

// File: rtl/cxo_raster.sv
// Raster position tracker.
// Column resets on hsync fall and steps by the lane count; line restarts on the
// first hsync fall after a vsync fall. Syncs are active low and synchronous.
module cxo_raster #(
    parameter int HW     = 16,
    parameter int VW     = 16,
    parameter int STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [STEP_W-1:0] step,
    output logic [HW-1:0]     h,
    output logic [VW-1:0]     v
);
    logic hs_d, vs_d, armed;
    logic hfall, vfall;

    // Edge detection against the previous sample.
    assign hfall = hs_d & ~hsync;
    assign vfall = vs_d & ~vsync;

    // Counter and frame-arm update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_d  <= 1'b1;
            vs_d  <= 1'b1;
            armed <= 1'b0;
            h     <= '0;
            v     <= '0;
        end else begin
            hs_d  <= hsync;
            vs_d  <= vsync;
            armed <= vfall | (armed & ~hfall);
            if (hfall) begin
                h <= '0;
                v <= armed ? '0 : v + 1'b1;
            end else begin
                h <= h + HW'(step);
            end
        end
    end

    // R7: hsync fall zeroes the column
    a_r7_hsync_zero: assert property (@(posedge clk) disable iff (!rst_n)
        hfall |=> (h == '0));
    // R6: otherwise the column steps by the lane count
    a_r6_h_step: assert property (@(posedge clk) disable iff (!rst_n)
        !hfall |=> (h == $past(h) + HW'($past(step))));
    // R8: first line after a vsync fall is line zero
    a_r8_v_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (hfall && armed && !vfall) |=> (v == '0));
endmodule

// File: rtl/cxo_bitmap.sv
// Cursor image store: DIM rows of DIM bits, written a byte at a time,
// read a whole row at a time without latency.
module cxo_bitmap #(
    parameter int DIM = 64,
    parameter int AW  = $clog2(DIM * DIM / 8)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [7:0]             wdata,
    input  logic [$clog2(DIM)-1:0] rrow,
    output logic [DIM-1:0]         row
);
    localparam int RIW = $clog2(DIM);
    localparam int BIW = AW - RIW;

    logic [DIM-1:0] mem [DIM];

    // Byte write into the addressed row; bit j of byte b is column 8*b+j.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DIM; r++) mem[r] <= '0;
        end else if (we) begin
            mem[waddr[AW-1:BIW]][{waddr[BIW-1:0], 3'b000} +: 8] <= wdata;
        end
    end

    // Row read for the current line.
    assign row = mem[rrow];
endmodule

// File: rtl/cursor_overlay.sv
// Cursor and crosshair overlay top.
// Evaluates LANES adjacent pixels per clock against the cursor square and
// windowed crosshair, merges them per the command and registers the result.
// Assumes positions already include the mode's pipeline offset.
module cursor_overlay
    import cxo_pkg::*;
#(
    parameter int CUR_DIM = 64,
    parameter int HW      = 16,
    parameter int OFF_1   = 37,
    parameter int OFF_4   = 52,
    parameter int OFF_5   = 57,
    parameter int MAP_AW  = $clog2(CUR_DIM * CUR_DIM / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [3:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              map_we,
    input  logic [MAP_AW-1:0] map_addr,
    input  logic [7:0]        map_wdata,
    input  logic              hsync,
    input  logic              vsync,
    output logic [LANES-1:0]  ovl
);
    localparam int DW  = HW + 2;
    localparam int CIW = $clog2(CUR_DIM);
    localparam logic signed [DW-1:0] DIM_S  = DW'(CUR_DIM);
    localparam logic signed [DW-1:0] ZERO_S = '0;

    cfg_t               cfg;
    mux_e               mux;
    logic [STEP_W-1:0]  nlanes;
    logic [DW-1:0]      off;
    logic [HW-1:0]      h;
    logic [HW-1:0]      v;
    logic [CUR_DIM-1:0] row_bits;
    logic signed [DW-1:0] dy, rad;
    logic               row_ok, dy_near, row_in_win;
    logic               cur_en, xh_en, or_mode;
    logic [LANES-1:0]   lane_bit;

    cxo_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .cfg(cfg)
    );

    assign mux     = mux_e'(cfg.cmd[3:2]);
    assign nlanes  = lanes_of(mux);
    assign cur_en  = cfg.cmd[6];
    assign xh_en   = cfg.cmd[5];
    assign or_mode = cfg.cmd[4];
    assign rad     = DW'(cfg.cmd[1:0]);

    // Pipeline offset for the active ratio.
    always_comb begin
        case (mux)
            MUX_4:   off = DW'(OFF_4);
            MUX_5:   off = DW'(OFF_5);
            default: off = DW'(OFF_1);
        endcase
    end

    cxo_raster #(.HW(HW), .VW(HW), .STEP_W(STEP_W)) u_raster (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .step(nlanes), .h(h), .v(v)
    );

    // Line-wide terms shared by all lanes.
    assign dy         = $signed(DW'(v) - DW'(cfg.ypos));
    assign row_ok     = (dy >= ZERO_S) && (dy < DIM_S);
    assign dy_near    = (dy <= rad) && (dy >= -rad);
    assign row_in_win = (DW'(v) >= DW'(cfg.wy)) && (DW'(v) < DW'(cfg.wy) + DW'(cfg.wh));

    cxo_bitmap #(.DIM(CUR_DIM), .AW(MAP_AW)) u_bitmap (
        .clk(clk), .rst_n(rst_n), .we(map_we), .waddr(map_addr),
        .wdata(map_wdata), .rrow(dy[CIW-1:0]), .row(row_bits)
    );

    // Per-lane hit tests.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam logic [STEP_W-1:0] KIDX = STEP_W'(k);
        logic [DW-1:0]        xabs;
        logic signed [DW-1:0] dx;
        logic                 on_cur, on_xh, col_in_win, on_line;

        assign xabs       = DW'(h) + DW'(k);
        assign dx         = $signed(xabs + off - DW'(cfg.xpos));
        assign on_cur     = cur_en && row_ok && (dx >= ZERO_S) && (dx < DIM_S)
                            && row_bits[dx[CIW-1:0]];
        assign col_in_win = (xabs >= DW'(cfg.wx)) && (xabs < DW'(cfg.wx) + DW'(cfg.ww));
        assign on_line    = ((dx <= rad) && (dx >= -rad)) || dy_near;
        assign on_xh      = xh_en && col_in_win && row_in_win && on_line;
        assign lane_bit[k] = (KIDX < nlanes) && (or_mode ? (on_cur | on_xh) : (on_cur ^ on_xh));
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) ovl <= '0;
        else        ovl <= lane_bit;
    end

    // R2: no enable, no overlay
    a_r2_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.cmd[6] && !cfg.cmd[5]) |=> (ovl == '0));
    // R6: 1:1 and reserved codes drive only lane 0
    a_r6_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cmd[3:2] == 2'b00 || cfg.cmd[3:2] == 2'b11) |=> (ovl[LANES-1:1] == '0));
    // R6: 4:1 leaves the fifth lane dark
    a_r6_four_lane: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cmd[3:2] == 2'b01) |=> (ovl[LANES-1] == 1'b0));
endmodule

// File: tb/cursor_overlay_bench.sv
// Frame sweeps in every mode, compared with an arithmetic coordinate model.
module cursor_overlay_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       map_we = 1'b0;
    logic [8:0] map_addr = '0;
    logic [7:0] map_wdata = '0;
    logic       hsync = 1'b1;
    logic       vsync = 1'b1;
    logic [4:0] ovl;

    always #4 clk = ~clk;   // 125 MHz

    cursor_overlay u_cursor_overlay (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .map_we(map_we), .map_addr(map_addr),
        .map_wdata(map_wdata), .hsync(hsync), .vsync(vsync), .ovl(ovl)
    );

    localparam int LINE = 90;
    int nvec = 0, nbad = 0;
    int cmd = 0, cx = 0, cy = 0, wx = 0, wy = 0, ww = 0, wh = 0;
    int hb = 0, vb = 0;
    bit armed = 0, hs_prev = 1, vs_prev = 1;
    logic [4:0] exp_q = '0;
    string tag = "R1";

    function automatic bit bm_bit(int r, int c);
        return ((r * 5 + c * 3) % 7 == 0) || (r == c);
    endfunction

    function automatic int nl(int c);
        case ((c >> 2) & 3)
            1: return 4;
            2: return 5;
            default: return 1;
        endcase
    endfunction

    function automatic int offs(int c);
        case ((c >> 2) & 3)
            1: return 52;
            2: return 57;
            default: return 37;
        endcase
    endfunction

    // Expected overlay for column h, line v under the current configuration.
    function automatic logic [4:0] model(int h, int v);
        logic [4:0] r = '0;
        int rad = cmd & 3;
        for (int k = 0; k < 5; k++) begin
            int x = h + k;
            int dx = x + offs(cmd) - cx;
            int dy = v - cy;
            bit c, xh, inw, line;
            c = ((cmd & 64) != 0) && dx >= 0 && dx < 64 && dy >= 0 && dy < 64
                && bm_bit(dy, dx);
            inw = x >= wx && x < wx + ww && v >= wy && v < wy + wh;
            line = (dx <= rad && dx >= -rad) || (dy <= rad && dy >= -rad);
            xh = ((cmd & 32) != 0) && inw && line;
            if (k < nl(cmd)) r[k] = ((cmd & 16) != 0) ? (c | xh) : (c ^ xh);
        end
        return r;
    endfunction

    // One clock: check last result, predict next, drive syncs, advance model.
    task automatic cyc(bit hs, bit vs, bit chk);
        bit hf, vf;
        @(negedge clk);
        if (chk) begin
            nvec++;
            if (ovl !== exp_q) begin
                nbad++;
                $display("FAIL %s: ovl=%b expected %b (col %0d line %0d)",
                         tag, ovl, exp_q, hb, vb);
            end
        end
        exp_q = model(hb, vb);
        hsync = hs;
        vsync = vs;
        hf = hs_prev && !hs;
        vf = vs_prev && !vs;
        if (hf) begin
            hb = 0;
            vb = armed ? 0 : vb + 1;
        end else begin
            hb = hb + nl(cmd);
        end
        armed = vf ? 1'b1 : (hf ? 1'b0 : armed);
        hs_prev = hs;
        vs_prev = vs;
    endtask

    task automatic wreg(int a, int d);
        reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
        cyc(1, 1, 0);
        reg_we = 1'b0;
    endtask

    // R9 layout; high position bytes carry junk above bit 3, unused addresses get junk.
    task automatic setup(int c, int x, int y, int wx_, int wy_, int ww_, int wh_);
        wreg(0, c);
        wreg(2, x & 255); wreg(3, ((x >> 8) & 15) | 8'hF0);
        wreg(4, y & 255); wreg(5, ((y >> 8) & 15) | 8'hA0);
        wreg(1, 8'hFF); wreg(6, 8'h5A); wreg(7, 8'hC3);
        wreg(8, wx_ & 255);  wreg(9, wx_ >> 8);
        wreg(10, wy_ & 255); wreg(11, wy_ >> 8);
        wreg(12, ww_ & 255); wreg(13, ww_ >> 8);
        wreg(14, wh_ & 255); wreg(15, wh_ >> 8);
        cmd = c; cx = x; cy = y; wx = wx_; wy = wy_; ww = ww_; wh = wh_;
        cyc(1, 1, 0); cyc(1, 1, 0);
    endtask

    // R8: vsync pulse, then lines each opened by an hsync pulse (R7).
    task automatic frame(int lines);
        repeat (3) cyc(1, 0, 0);
        repeat (2) cyc(1, 1, 0);
        for (int ln = 0; ln < lines; ln++) begin
            cyc(0, 1, ln > 0);
            cyc(0, 1, 1);
            repeat (LINE - 2) cyc(1, 1, 1);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state and idle output
        tag = "R1 reset";
        repeat (20) cyc(1, 1, 1);
        // R3 image load: byte a is row a/8, bit j is column 8*(a%8)+j
        for (int a = 0; a < 512; a++) begin
            logic [7:0] b;
            for (int j = 0; j < 8; j++) b[j] = bm_bit(a / 8, (a % 8) * 8 + j);
            map_we = 1'b1; map_addr = 9'(a); map_wdata = b;
            cyc(1, 1, 0);
        end
        map_we = 1'b0;

        tag = "R3/R9 cursor 1:1";
        setup(8'h40, 37 + 10, 3, 0, 0, 0, 0);        frame(70);
        tag = "R4 crosshair thick 3";
        setup(8'h21, 37 + 40, 30, 5, 2, 70, 60);     frame(70);
        tag = "R5/R6 OR 4:1";
        setup(8'h74, 52 + 21, 5, 0, 0, 300, 100);    frame(70);
        tag = "R5/R6 XOR 5:1 thick 7";
        setup(8'h6B, 57 + 33, 10, 11, 4, 203, 50);   frame(70);
        tag = "R6 reserved ratio thick 5";
        setup(8'h7E, 37 + 20, 20, 3, 0, 77, 90);     frame(70);
        tag = "R2 enables clear";
        setup(8'h1B, 57 + 30, 10, 0, 0, 400, 100);   frame(70);
        tag = "R4 zero window";
        setup(8'h61, 37 + 15, 6, 0, 0, 0, 0);        frame(70);

        summary();
        $finish;
    end
endmodule